// File: doc/BRIEF.md
# Input-Capture Timer Channel

This block is a single channel of a general-purpose timer. A programmable prescaler divides the clock. Each time the prescaler reaches its terminal count, a free-running internal counter advances by one. Software cannot read or write that counter. Its value becomes visible only when a selected event on the external input pin copies it into the capture register. The time between two events is the difference of two successive captured values. The 16-bit prescaler and the 16-bit counter together span 32 bits of time, at 16-bit resolution.

The event can be any transition, a rising transition, a falling transition, or a two-edge pulse. In normal capture mode only the hidden counter runs. In up mode, a software-visible event counter also increments once on every capture event. A capture can set a sticky interrupt flag, which software clears by writing one. A channel enable holds both counters at zero while it is low.

Top module: `tcap_channel`

## Requirements
- R1: After reset, `capture_o`, `event_count_o` and `irq_o` are all zero.
- R2: While `enable_i` is low, the internal counter and the event counter are held at zero, the interrupt flag is cleared, and pin activity changes nothing. After `enable_i` returns high, counting restarts from zero.
- R3: While enabled, the internal counter advances by one every `prescale_i`+1 clock cycles. After n enabled clock edges it holds floor(n/(`prescale_i`+1)) modulo 65536, so it wraps from 0xFFFF to 0x0000.
- R4: The pin passes through a two-flop synchronizer. The event select `edge_sel_i` takes 00 for any transition, 01 for rising and 10 for falling. A change first sampled at clock edge k is captured at edge k+2, and `capture_o` then holds the value the internal counter had just before edge k+2.
- R5: With `edge_sel_i` = 11 (pulse), any edge arms the channel, and the next edge captures and disarms it. Arming is lost when `mode_i` or `edge_sel_i` changes or when the channel is disabled.
- R6: With `mode_i` = 01 (up mode), `event_count_o` increments by exactly one per capture event. With `mode_i` = 00 (normal capture), and also with the unused codes 10 and 11, it stays at zero while captures still take place.
- R7: A capture sets the interrupt flag `irq_o` only when `irq_en_i` is high. The flag stays set until `irq_clr_i` is high for a cycle. If a capture and a clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Channel enable; low holds counters at zero |
| mode_i | input | 2 | 00 normal capture, 01 up mode, others act as 00 |
| edge_sel_i | input | 2 | 00 any, 01 rising, 10 falling, 11 pulse |
| irq_en_i | input | 1 | Interrupt enable for capture events |
| prescale_i | input | 16 | Prescaler terminal count; counter period is value+1 cycles |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| pin_i | input | 1 | Asynchronous external timer pin |
| capture_o | output | 16 | Last captured internal counter value |
| event_count_o | output | 16 | Software-visible event counter (up mode) |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The hardest states to reach from the ports are an armed pulse capture whose arming must be dropped by a configuration change, and a flag clear that lands in the exact cycle of a capture. The stimulus arms the pulse detector with one pin edge and then toggles the event select away and back. It then shows that the opposite edge only re-arms, and the edge after that is the one that captures. For the collision, the clear strobe is placed in the cycle between the second synchronizer stage and the capture edge. That cycle is found by counting registers from the pin change. The counter wrap is reached by running the counter unprescaled for more than 65536 cycles before a capture.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        EDGE_ANY   = 2'b00,
        EDGE_RISE  = 2'b01,
        EDGE_FALL  = 2'b10,
        EDGE_PULSE = 2'b11
    } edge_sel_e;

    localparam logic [1:0] MODE_CAPTURE = 2'b00;
    localparam logic [1:0] MODE_UP      = 2'b01;

endpackage

// File: rtl/tcap_edge_detect.sv
module tcap_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    // STAGES must be at least 2

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sync_q[STAGES-1] & prev_q;

    // R4: a sampled level change shows up as exactly one edge one cycle later
    a_r4_edge_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
    a_r4_edge_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[STAGES-1] != sync_q[STAGES-2]) |=> (rise_o || fall_o));

endmodule

// File: rtl/tcap_timebase.sv
module tcap_timebase #(
    parameter int PRE_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [PRE_W-1:0] prescale_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      terminal;

    always_comb begin
        st_d     = st_q;
        terminal = (st_q.pre >= prescale_i);
        if (!enable_i) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else if (terminal) begin
            st_d.pre = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    // R2: disabled channel holds the counter at zero
    a_r2_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (count_o == '0));
    // R3: counter only moves when the prescaler has run its full period
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && st_q.pre < prescale_i) |=> (count_o == $past(count_o)));
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && st_q.pre >= prescale_i) |=> (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/tcap_capture_unit.sv
module tcap_capture_unit
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       mode_i,
    input  edge_sel_e        edge_sel_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] capture_o,
    output logic [CNT_W-1:0] events_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] events;
        logic             armed;
        logic             irq;
        logic [3:0]       cfg;
    } cu_state_t;

    cu_state_t st_d, st_q;
    logic      any_edge;
    logic      fire;
    logic      cfg_changed;

    always_comb begin
        st_d        = st_q;
        any_edge    = rise_i | fall_i;
        st_d.cfg    = {mode_i, edge_sel_i};
        cfg_changed = (st_d.cfg != st_q.cfg);

        unique case (edge_sel_i)
            EDGE_ANY:   fire = any_edge;
            EDGE_RISE:  fire = rise_i;
            EDGE_FALL:  fire = fall_i;
            EDGE_PULSE: fire = any_edge & st_q.armed;
            default:    fire = 1'b0;
        endcase
        fire = fire & enable_i;

        if (!enable_i || cfg_changed || edge_sel_i != EDGE_PULSE) begin
            st_d.armed = 1'b0;
        end else if (any_edge) begin
            st_d.armed = ~st_q.armed;
        end

        if (fire) st_d.cap = count_i;

        if (!enable_i) begin
            st_d.events = '0;
        end else if (fire && mode_i == MODE_UP) begin
            st_d.events = st_q.events + 1'b1;
        end

        if (!enable_i) begin
            st_d.irq = 1'b0;
        end else if (fire && irq_en_i) begin
            st_d.irq = 1'b1;
        end else if (irq_clr_i) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capture_o = st_q.cap;
    assign events_o  = st_q.events;
    assign irq_o     = st_q.irq;

    // R2: disabled channel clears the event counter and the flag
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (events_o == '0 && !irq_o));
    // R4: no edge from the detector means the capture register is untouched
    a_r4_no_edge_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !fall_i) |=> $stable(capture_o));
    // R4: a rising-edge event latches the counter value of that cycle
    a_r4_rise_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && edge_sel_i == EDGE_RISE && rise_i) |=> (capture_o == $past(count_i)));
    // R6: up mode with any-edge events counts each edge once
    a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && mode_i == MODE_UP && edge_sel_i == EDGE_ANY && (rise_i || fall_i))
        |=> (events_o == $past(events_o) + 1'b1));
    a_r6_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !rise_i && !fall_i) |=> $stable(events_o));
    // R7: the flag holds unless cleared or disabled
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && enable_i && !irq_clr_i) |=> irq_o);
    a_r7_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !irq_en_i) |=> !irq_o);

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int PRE_W       = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             irq_en_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic             irq_clr_i,
    input  logic             pin_i,
    output logic [CNT_W-1:0] capture_o,
    output logic [CNT_W-1:0] event_count_o,
    output logic             irq_o
);
    logic             rise;
    logic             fall;
    logic [CNT_W-1:0] count;
    edge_sel_e        edge_sel;

    assign edge_sel = edge_sel_e'(edge_sel_i);

    tcap_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tcap_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .prescale_i (prescale_i),
        .count_o    (count)
    );

    tcap_capture_unit #(.CNT_W(CNT_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .mode_i     (mode_i),
        .edge_sel_i (edge_sel),
        .irq_en_i   (irq_en_i),
        .irq_clr_i  (irq_clr_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .count_i    (count),
        .capture_o  (capture_o),
        .events_o   (event_count_o),
        .irq_o      (irq_o)
    );

    // R1: outputs are zero in the first cycle after reset release
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (capture_o == '0 && event_count_o == '0 && !irq_o));

endmodule

// File: tb/tb_tcap_channel.sv
module tb_tcap_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  edge_sel = 2'b00;
    logic        irq_en = 1'b0;
    logic [15:0] prescale = '0;
    logic        irq_clr = 1'b0;
    logic        pin = 1'b0;
    logic [15:0] capture;
    logic [15:0] event_count;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    int pre_v = 0;
    int en_edges = 0;

    always #2 clk = ~clk;

    tcap_channel dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable),
        .mode_i        (mode),
        .edge_sel_i    (edge_sel),
        .irq_en_i      (irq_en),
        .prescale_i    (prescale),
        .irq_clr_i     (irq_clr),
        .pin_i         (pin),
        .capture_o     (capture),
        .event_count_o (event_count),
        .irq_o         (irq)
    );

    // Number of consecutive enabled clock edges (timebase model input)
    always @(posedge clk) begin
        if (!rst_n || !enable) en_edges <= 0;
        else                   en_edges <= en_edges + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Drive a pin level at a negedge; return the counter value expected in the
    // capture register. Returns at the negedge between edges k+1 and k+2.
    task automatic drive_edge(input logic lvl, output logic [15:0] exp_cap);
        @(negedge clk) pin = lvl;
        @(posedge clk);
        @(posedge clk);
        #1 exp_cap = 16'((en_edges / (pre_v + 1)) % 65536);
        @(negedge clk);
    endtask

    task automatic restart(input int p);
        @(negedge clk) enable = 1'b0;
        prescale = 16'(p);
        pre_v = p;
        repeat (2) @(negedge clk);
        enable = 1'b1;
    endtask

    // {edge_sel, mode, start, irq_en, toggles, exp_events, exp_irq}
    localparam int NV = 10;
    localparam logic [14:0] VECS [NV] = '{
        {2'b00, 2'b01, 1'b0, 1'b1, 4'd4, 4'd4, 1'b1},
        {2'b01, 2'b01, 1'b0, 1'b1, 4'd4, 4'd2, 1'b1},
        {2'b10, 2'b01, 1'b0, 1'b1, 4'd4, 4'd2, 1'b1},
        {2'b01, 2'b01, 1'b1, 1'b1, 4'd3, 4'd1, 1'b1},
        {2'b11, 2'b01, 1'b0, 1'b1, 4'd4, 4'd2, 1'b1},
        {2'b11, 2'b01, 1'b0, 1'b1, 4'd3, 4'd1, 1'b1},
        {2'b00, 2'b00, 1'b0, 1'b1, 4'd4, 4'd0, 1'b1},
        {2'b00, 2'b10, 1'b0, 1'b1, 4'd3, 4'd0, 1'b1},
        {2'b00, 2'b01, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0},
        {2'b10, 2'b01, 1'b0, 1'b1, 4'd1, 4'd0, 1'b0}
    };

    initial begin
        #(4 * 190000);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] e;
        logic [15:0] held;
        logic        lvl;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 capture", 32'(capture), 32'h0);
        chk("R1 event_count", 32'(event_count), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 capture after release", 32'(capture), 32'h0);

        // Vector table: event selection, modes and interrupt enable
        for (int v = 0; v < NV; v++) begin
            @(negedge clk) enable = 1'b0;
            edge_sel = VECS[v][14:13];
            mode     = VECS[v][12:11];
            pin      = VECS[v][10];
            irq_en   = VECS[v][9];
            prescale = '0;
            pre_v    = 0;
            lvl      = VECS[v][10];
            repeat (4) @(negedge clk);
            enable = 1'b1;
            for (int t = 0; t < int'(VECS[v][8:5]); t++) begin
                lvl = ~lvl;
                drive_edge(lvl, e);
                repeat (3) @(negedge clk);
            end
            chk($sformatf("R6 R4 R5 vector %0d event_count", v), 32'(event_count), 32'(VECS[v][4:1]));
            chk($sformatf("R7 vector %0d irq", v), 32'(irq), 32'(VECS[v][0]));
        end

        // R4: captured value equals the internal counter, prescale 0
        @(negedge clk) edge_sel = 2'b00; mode = 2'b01; irq_en = 1'b1; pin = 1'b0;
        restart(0);
        repeat (10) @(negedge clk);
        drive_edge(1'b1, e);
        @(negedge clk);
        chk("R4 capture on rise", 32'(capture), 32'(e));
        repeat (7) @(negedge clk);
        drive_edge(1'b0, e);
        @(negedge clk);
        chk("R4 capture on fall", 32'(capture), 32'(e));

        // R3: prescaler of 3 divides the counter rate by four
        restart(3);
        repeat (13) @(negedge clk);
        drive_edge(1'b1, e);
        @(negedge clk);
        chk("R3 prescaled capture", 32'(capture), 32'(e));
        repeat (9) @(negedge clk);
        drive_edge(1'b0, e);
        @(negedge clk);
        chk("R3 prescaled capture second", 32'(capture), 32'(e));

        // R7: write-one clear, then capture/clear collision
        chk("R7 flag set before clear", 32'(irq), 32'h1);
        irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R7 flag cleared", 32'(irq), 32'h0);
        drive_edge(1'b1, e);
        @(negedge clk);
        chk("R7 flag set by capture", 32'(irq), 32'h1);
        repeat (3) @(negedge clk);
        drive_edge(1'b0, e);
        irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        chk("R7 capture wins over clear", 32'(irq), 32'h1);

        // R2: disable clears counters and flag, pin ignored
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 event_count zero", 32'(event_count), 32'h0);
        chk("R2 irq cleared", 32'(irq), 32'h0);
        held = capture;
        pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 capture untouched while disabled", 32'(capture), 32'(held));
        pre_v = 0;
        prescale = '0;
        enable = 1'b1;
        drive_edge(1'b0, e);
        @(negedge clk);
        chk("R2 counter restarts from zero", 32'(capture), 32'(e));
        chk("R2 restart value small", 32'(capture < 16'd8), 32'h1);

        // R5: arming lost on configuration change
        @(negedge clk) edge_sel = 2'b11; mode = 2'b01;
        restart(0);
        repeat (3) @(negedge clk);
        drive_edge(1'b1, e);          // arms
        repeat (3) @(negedge clk);
        edge_sel = 2'b01;
        repeat (2) @(negedge clk);
        edge_sel = 2'b11;
        repeat (2) @(negedge clk);
        held = capture;
        drive_edge(1'b0, e);          // only re-arms
        repeat (3) @(negedge clk);
        chk("R5 disarmed edge no count", 32'(event_count), 32'h0);
        chk("R5 disarmed edge no capture", 32'(capture), 32'(held));
        drive_edge(1'b1, e);          // completes the pulse
        @(negedge clk);
        chk("R5 pulse capture value", 32'(capture), 32'(e));
        chk("R5 pulse counted once", 32'(event_count), 32'h1);

        // R3: counter wraps past 0xFFFF
        @(negedge clk) edge_sel = 2'b00; pin = 1'b0;
        restart(0);
        repeat (65540) @(negedge clk);
        drive_edge(1'b1, e);
        @(negedge clk);
        chk("R3 wrap capture", 32'(capture), 32'(e));
        chk("R3 wrap value small", 32'(capture < 16'd16), 32'h1);

        finish_run();
    end

endmodule